// File: doc/BRIEF.md
# Serial DAC Word Writer

This block writes one sample word at a time to a serial digital-to-analog converter over a write-only, SPI-style link. A word arrives on a valid/ready input. On acceptance it is captured and shifted out most significant bit first while the chip select is low. The serial clock is a divided copy of the system clock, produced through a clock-enable counter. Every register runs on the system clock, and the divided clock only ever leaves the block as an output pin.

When the last bit has been sent, chip select returns high. After a programmable gap, an active-low load strobe pulses so the converter moves the word from its input register to its output latch. A parameter can instead hold the strobe low at all times, so the latch follows the input register directly and the word ends when chip select rises. `busy` covers the whole sequence. `done` marks its end for one cycle.

The input follows valid/ready rules. `in_ready` is high only while the writer is idle. A word transfers on any rising clock edge where `in_valid` and `in_ready` are both high. A source facing a low `in_ready` keeps its word and waits; nothing is queued inside the block.

Top module: `dac_spi_writer`

## Requirements
- R1: A word is accepted only on an edge where `in_valid` and `in_ready` are both high, and `in_ready` is high exactly when the writer is idle. `in_data` is captured at acceptance, so later changes on `in_data` do not affect the word being sent.
- R2: `cs_n` goes low in the cycle after acceptance and stays low for exactly 2·SCLK_HALF·DATA_W system cycles.
- R3: `sclk` rests low whenever `cs_n` is high. During a word it starts low and toggles every SCLK_HALF system cycles, giving DATA_W rising edges. The default SCLK_HALF=2 gives one quarter of the system clock.
- R4: `sdo` carries the captured word most significant bit first. It changes only in the cycle where `sclk` falls, so it is stable at every rising edge. It is 0 while `cs_n` is high.
- R5: With the strobe in pulsed mode, `load_n` stays high while `cs_n` is low, and it falls exactly LOAD_GAP cycles after `cs_n` rises.
- R6: In pulsed mode, `load_n` stays low for exactly LOAD_LEN cycles and then returns high.
- R7: With LOAD_TIED_LOW=1, `load_n` is low in every cycle, and the word ends in the cycle in which `cs_n` rises.
- R8: `busy` is high from the cycle after acceptance until the load pulse has ended (or until `cs_n` rises in tied mode), and it is the inverse of `in_ready`.
- R9: `done` is high for exactly one cycle: the first idle cycle after a word. A new word may be accepted in that cycle.
- R10: A synchronous `rst` returns the block to idle with `cs_n` high, `sclk` low, `sdo` low, `load_n` high (low in tied mode), `busy` and `done` low, and `in_ready` high. This also applies in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Writer idle and able to take a word |
| in_data | input | DATA_W | Sample word to send |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdo | output | 1 | Serial data to the converter |
| load_n | output | 1 | Latch load strobe, active low |

## Verification
The bench builds three copies of the writer side by side.

The first uses the defaults: clock divided by four, a two-cycle gap and a two-cycle strobe. The second runs at the fastest divide setting (SCLK_HALF=1) with the strobe tied low, so it covers the tied-mode ending and back-to-back words with no gap. The third uses SCLK_HALF=3 with a one-cycle gap and a three-cycle strobe, which exposes any off-by-one in the divider and in the gap and strobe counters.

All three share one input stream. Because their word lengths differ, the same valid pattern meets busy and idle writers at different times, which exercises both acceptance and waiting.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_SHIFT = 2'd1,
    WR_GAP   = 2'd2,
    WR_LOAD  = 2'd3
  } wr_state_t;
endpackage

// File: rtl/dac_sclk_div.sv
module dac_sclk_div #(
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_tick
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick      = run && (cnt_q == LAST);
  assign fall_tick = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // once the divider is stopped the clock pin must sit low
  p_sclk_rests_low_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk);
endmodule

// File: rtl/dac_shift_reg.sv
module dac_shift_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              msb
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign msb = sh_q[DATA_W-1];
endmodule

// File: rtl/dac_spi_writer.sv
module dac_spi_writer
  import dac_spi_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int SCLK_HALF     = 2,
  parameter int LOAD_GAP      = 2,
  parameter int LOAD_LEN      = 2,
  parameter bit LOAD_TIED_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo,
  output logic              load_n
);
  localparam int BW   = $clog2(DATA_W);
  localparam int TMAX = (LOAD_GAP > LOAD_LEN) ? LOAD_GAP : LOAD_LEN;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);
  localparam logic [TW-1:0] GAP_END  = TW'(LOAD_GAP - 1);
  localparam logic [TW-1:0] LOAD_END = TW'(LOAD_LEN - 1);

  wr_state_t     st_q;
  logic [BW-1:0] bit_q;
  logic [TW-1:0] tmr_q;
  logic          fall_tick;
  logic          shift_msb;
  logic          accept;
  logic          last_fall;

  assign accept    = in_valid && (st_q == WR_IDLE);
  assign last_fall = (st_q == WR_SHIFT) && fall_tick && (bit_q == LAST_BIT);

  dac_sclk_div #(.SCLK_HALF(SCLK_HALF)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (st_q == WR_SHIFT),
    .sclk      (sclk),
    .fall_tick (fall_tick)
  );

  dac_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .shift ((st_q == WR_SHIFT) && fall_tick && !last_fall),
    .din   (in_data),
    .msb   (shift_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WR_IDLE;
      bit_q <= '0;
      tmr_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        WR_IDLE: begin
          if (accept) begin
            st_q  <= WR_SHIFT;
            bit_q <= '0;
          end
        end
        WR_SHIFT: begin
          if (last_fall) begin
            tmr_q <= '0;
            if (LOAD_TIED_LOW) begin
              st_q <= WR_IDLE;
              done <= 1'b1;
            end else begin
              st_q <= WR_GAP;
            end
          end else if (fall_tick) begin
            bit_q <= bit_q + 1'b1;
          end
        end
        WR_GAP: begin
          if (tmr_q == GAP_END) begin
            st_q  <= WR_LOAD;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        WR_LOAD: begin
          if (tmr_q == LOAD_END) begin
            st_q <= WR_IDLE;
            done <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= WR_IDLE;
      endcase
    end
  end

  assign in_ready = (st_q == WR_IDLE);
  assign busy     = (st_q != WR_IDLE);
  assign cs_n     = (st_q != WR_SHIFT);
  assign sdo      = (st_q == WR_SHIFT) && shift_msb;

  generate
    if (LOAD_TIED_LOW) begin : g_tied
      assign load_n = 1'b0;
    end else begin : g_pulsed
      assign load_n = (st_q != WR_LOAD);

      p_load_high_selected_r5: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> load_n);
      p_load_falls_deselected_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(load_n) |-> cs_n);
    end
  endgenerate

  p_accept_starts_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !cs_n && busy);
  p_sclk_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk && !sdo);
  p_sdo_moves_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !cs_n && $past(!cs_n) && !$fell(sclk) |-> $stable(sdo));
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);
endmodule

// File: tb/dac_spi_writer_test.sv
module dac_spi_writer_test;
  localparam int N = 3;
  localparam int W = 16;
  localparam int HH [N] = '{2, 1, 3};
  localparam int GG [N] = '{2, 2, 1};
  localparam int LL [N] = '{2, 2, 3};
  localparam int TT [N] = '{0, 1, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [N-1:0] rdy, bsy, dn, csn, sck, sd, ldn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit rst_seen = 1'b0;

  int t  [N];
  bit df [N];
  logic [W-1:0] dat [N];

  always #2 clk = ~clk;

  dac_spi_writer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[0]), .in_data(in_data),
    .busy(bsy[0]), .done(dn[0]), .cs_n(csn[0]), .sclk(sck[0]), .sdo(sd[0]), .load_n(ldn[0]));

  dac_spi_writer #(.SCLK_HALF(1), .LOAD_TIED_LOW(1'b1)) uut_b (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[1]), .in_data(in_data),
    .busy(bsy[1]), .done(dn[1]), .cs_n(csn[1]), .sclk(sck[1]), .sdo(sd[1]), .load_n(ldn[1]));

  dac_spi_writer #(.SCLK_HALF(3), .LOAD_GAP(1), .LOAD_LEN(3)) uut_c (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[2]), .in_data(in_data),
    .busy(bsy[2]), .done(dn[2]), .cs_n(csn[2]), .sclk(sck[2]), .sdo(sd[2]), .load_n(ldn[2]));

  function automatic int word_end(int i);
    int ts = 2 * HH[i] * W;
    return TT[i] != 0 ? ts : ts + GG[i] + LL[i];
  endfunction

  // expected {ready, busy, done, cs_n, sclk, sdo, load_n}
  function automatic logic [6:0] expect_out(int i);
    int ts = 2 * HH[i] * W;
    logic idle_ld = (TT[i] != 0) ? 1'b0 : 1'b1;
    if (t[i] < 0) return {1'b1, 1'b0, df[i], 1'b1, 1'b0, 1'b0, idle_ld};
    if (t[i] < ts) begin
      int b = t[i] / (2 * HH[i]);
      return {1'b0, 1'b1, 1'b0, 1'b0, 1'((t[i] / HH[i]) % 2), dat[i][W-1-b], idle_ld};
    end
    if (t[i] < ts + GG[i]) return {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    return {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  endfunction

  // reference model advances at each rising edge
  always @(posedge clk) begin
    started  <= 1'b1;
    rst_seen <= rst;
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        t[i] = -1; df[i] = 1'b0;
      end else if (t[i] < 0) begin
        df[i] = 1'b0;
        if (in_valid) begin
          t[i] = 0; dat[i] = in_data; // R1: capture at acceptance only
        end
      end else begin
        t[i] = t[i] + 1;
        if (t[i] == word_end(i)) begin
          t[i] = -1; df[i] = 1'b1;
        end
      end
    end
  end

  // compare all outputs away from the active edge
  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < N; i++) begin
        logic [6:0] got, exp;
        got = {rdy[i], bsy[i], dn[i], csn[i], sck[i], sd[i], ldn[i]};
        exp = expect_out(i);
        checks++;
        if (got !== exp) begin
          string req;
          errors++;
          if (rst_seen)              req = "R10";
          else if (got[6] !== exp[6]) req = "R1";
          else if (got[5] !== exp[5]) req = "R8";
          else if (got[4] !== exp[4]) req = "R9";
          else if (got[3] !== exp[3]) req = "R2";
          else if (got[2] !== exp[2]) req = "R3";
          else if (got[1] !== exp[1]) req = "R4";
          else if (TT[i] != 0)        req = "R7";
          else                        req = "R5,R6";
          $display("FAIL %s inst=%0d cycle=%0d got=%b expected=%b (rdy,busy,done,cs_n,sclk,sdo,load_n)",
                   req, i, cycles, got, exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d, expected end of run", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    for (int i = 0; i < N; i++) begin t[i] = -1; df[i] = 1'b0; dat[i] = '0; end
    step(3);                           // R10: reset state compared each cycle
    rst = 1'b0;
    // back-to-back words, data churning while busy (R1, R9)
    in_valid = 1'b1;
    for (int k = 0; k < 500; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_data = lfsr;
      step(1);
    end
    in_valid = 1'b0;
    step(120);
    // isolated one-cycle offers with corner patterns (R4)
    for (int k = 0; k < 9; k++) begin
      in_data  = (k % 3 == 0) ? 16'hFFFF : (k % 3 == 1) ? 16'h0000 : 16'h8001;
      in_valid = 1'b1;
      step(1);
      in_valid = 1'b0;
      in_data  = ~in_data;
      step(k * 17 + 20);
    end
    // reset in the middle of a word (R10)
    in_data  = 16'h5A3C;
    in_valid = 1'b1;
    step(1);
    in_valid = 1'b0;
    step(25);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(5);
    in_data  = 16'hC0F3;
    in_valid = 1'b1;
    step(400);
    in_valid = 1'b0;
    step(150);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule